// File: doc/BRIEF.md
# Four-Pin GPIO Port Controller with Power-Down Pad Settings

This block holds the control state for one general-purpose I/O port of four pins and turns it into per-pin pad controls. A simple bus slave gives read and write access to five word-aligned registers: a data register, a normal-mode pull selection, a drive strength selection, a power-down pin mode and a power-down pull selection. For each pin the block drives an output enable, an output level, a pull-up enable, a pull-down enable and a decoded drive strength level.

The direction of each pin comes from a mode input owned by a separate function-select block. Each pin is an input, an output or an alternate-function pin. A power-down request input moves the port between two named states. In `ST_RUN` the pads follow the normal registers. In `ST_SLEEP` they follow the power-down registers. The transition `RUN_TO_SLEEP` is taken on the clock edge where the request is seen high in `ST_RUN`. The transition `SLEEP_TO_RUN` is taken on the edge where the request is seen low in `ST_SLEEP`. On `RUN_TO_SLEEP` the block also captures every pin's output enable and output level, for use by pins set to hold their state.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset the registers read: data 0x00, pull 0x0055 (pull-down on every pin), drive 0x0000, power-down mode 0x00, power-down pull 0x00.
- R2: The register offsets are data 0x24, pull 0x28, drive 0x2C, power-down mode 0x30 and power-down pull 0x34. Each register is written whole, with no byte strobes. A pull, drive or mode register reads back bits [7:0] as written. Every bit above a register's field width reads as 0; for the data register that is every bit above [3:0].
- R3: The pin mode input has a 2-bit field per pin at [2n+1:2n], with 00 = input, 01 = output, and 10 or 11 = alternate function. Reading the data register returns, for each pin, the live `pin_in` level if the pin is an input, the stored data bit if it is an output, and 0 if it is an alternate-function pin.
- R4: In `ST_RUN` an output pin has its output enable set and drives its data register bit. Input pins and alternate-function pins have output enable 0 and output level 0.
- R5: The pull fields sit at [2n+1:2n], with 00 = none, 01 = pull-down, 10 = pull-up. Code 11 enables neither pull. Pull-up and pull-down are never enabled together on one pin.
- R6: The drive field at [2n+1:2n] is decoded to a level on `pad_drv[3n+2:3n]`: 00 gives 1, 10 gives 2, 01 gives 3 and 11 gives 4.
- R7: In `ST_SLEEP` the power-down mode field at [2n+1:2n] sets the pin. Code 00 drives 0 with the output enabled, code 01 drives 1 with the output enabled, and code 10 releases the pin (output enable 0, level 0).
- R8: In `ST_SLEEP` a pin with power-down mode 11 keeps the output enable and level that it had on the clock edge of `RUN_TO_SLEEP`. Writes to the data register during `ST_SLEEP` do not change that pin.
- R9: The power-down pull register sets the pulls only in `ST_SLEEP`. The normal pull register sets them only in `ST_RUN`.
- R10: One clock edge after `pwr_down` is seen low in `ST_SLEEP`, the pads follow the normal registers again. Entering or leaving power-down changes no register contents.
- R11: A read from an offset that is not mapped returns 0. A write to such an offset changes no register.
- R12: A high `pwr_down` seen in `ST_RUN` moves the port to `ST_SLEEP` on that clock edge, and the port stays in `ST_SLEEP` while the request stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset from the port base |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; combinational, 0 when no read is active |
| pin_mode | input | 8 | Per-pin mode from the function-select block |
| pin_in | input | 4 | Live pad input levels |
| pwr_down | input | 1 | Power-down request |
| pad_oe | output | 4 | Per-pin output enable |
| pad_out | output | 4 | Per-pin output level |
| pad_pu | output | 4 | Per-pin pull-up enable |
| pad_pd | output | 4 | Per-pin pull-down enable |
| pad_drv | output | 12 | Per-pin drive level 1 to 4, three bits per pin |

## Verification
The bench builds the block with its default parameters: four pins, an 8-bit offset and a 32-bit data word. With these values every pin's fields can be given a different code in a single write. One register write therefore covers all four pull codes, all four drive codes and all four power-down modes together. The power-down pass sets one pin to each mode and one pin to each pull code. It then writes the data register while the port is asleep, which shows that the held pin uses the level captured on entry and not the stored register value.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;

    // Register byte offsets from the port base
    localparam int unsigned OFF_DATA   = 32'h24;
    localparam int unsigned OFF_PULL   = 32'h28;
    localparam int unsigned OFF_DRIVE  = 32'h2C;
    localparam int unsigned OFF_PDMODE = 32'h30;
    localparam int unsigned OFF_PDPULL = 32'h34;

    // Pin direction codes from the function-select block
    localparam logic [1:0] PMODE_IN  = 2'b00;
    localparam logic [1:0] PMODE_OUT = 2'b01;

    // Pull field codes
    localparam logic [1:0] PULL_NONE = 2'b00;
    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b10;

    // Power-down pin behaviour codes
    localparam logic [1:0] PDM_LOW   = 2'b00;
    localparam logic [1:0] PDM_HIGH  = 2'b01;
    localparam logic [1:0] PDM_INPUT = 2'b10;
    localparam logic [1:0] PDM_KEEP  = 2'b11;

    // Reset image of the normal pull register for one pin
    localparam logic [1:0] PULL_RESET_FIELD = PULL_DOWN;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } pwr_state_e;

    // Non-monotonic drive code to strength level
    function automatic logic [2:0] drive_level(input logic [1:0] code);
        logic [2:0] lvl;
        unique case (code)
            2'b00:   lvl = 3'd1;
            2'b10:   lvl = 3'd2;
            2'b01:   lvl = 3'd3;
            default: lvl = 3'd4;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [2*NPINS-1:0] pin_mode,
    input  logic [NPINS-1:0]   pin_in,
    output logic [NPINS-1:0]   data_q,
    output logic [2*NPINS-1:0] pull_q,
    output logic [2*NPINS-1:0] drv_q,
    output logic [2*NPINS-1:0] pdm_q,
    output logic [2*NPINS-1:0] pdpull_q
);

    localparam int FW = 2 * NPINS;

    logic hit_data, hit_pull, hit_drv, hit_pdm, hit_pdpull, hit_any;
    logic wr_en, rd_en;
    logic [NPINS-1:0] data_view;
    logic [FW-1:0]    pull_reset;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DW-1:FW];

    assign hit_data   = (bus_addr == AW'(OFF_DATA));
    assign hit_pull   = (bus_addr == AW'(OFF_PULL));
    assign hit_drv    = (bus_addr == AW'(OFF_DRIVE));
    assign hit_pdm    = (bus_addr == AW'(OFF_PDMODE));
    assign hit_pdpull = (bus_addr == AW'(OFF_PDPULL));
    assign hit_any    = hit_data | hit_pull | hit_drv | hit_pdm | hit_pdpull;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            assign pull_reset[2*p +: 2] = PULL_RESET_FIELD;

            // Data readback depends on the pin's direction
            always_comb begin
                if (pin_mode[2*p +: 2] == PMODE_IN) begin
                    data_view[p] = pin_in[p];
                end else if (pin_mode[2*p +: 2] == PMODE_OUT) begin
                    data_view[p] = data_q[p];
                end else begin
                    data_view[p] = 1'b0;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            pull_q   <= pull_reset;
            drv_q    <= '0;
            pdm_q    <= '0;
            pdpull_q <= '0;
        end else if (wr_en) begin
            if (hit_data)   data_q   <= bus_wdata[NPINS-1:0];
            if (hit_pull)   pull_q   <= bus_wdata[FW-1:0];
            if (hit_drv)    drv_q    <= bus_wdata[FW-1:0];
            if (hit_pdm)    pdm_q    <= bus_wdata[FW-1:0];
            if (hit_pdpull) pdpull_q <= bus_wdata[FW-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (1'b1)
                hit_data:   bus_rdata = DW'(data_view);
                hit_pull:   bus_rdata = DW'(pull_q);
                hit_drv:    bus_rdata = DW'(drv_q);
                hit_pdm:    bus_rdata = DW'(pdm_q);
                hit_pdpull: bus_rdata = DW'(pdpull_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    // R11: a write to an unmapped offset leaves every register unchanged
    a_r11_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any) |=> ($stable(data_q) && $stable(pull_q) && $stable(drv_q)
                                 && $stable(pdm_q) && $stable(pdpull_q)));

    // R2: the data register changes only through a write at its own offset
    a_r2_data_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_data) |=> $stable(data_q));

endmodule

// File: rtl/gpio_pd_pwr_fsm.sv
module gpio_pd_pwr_fsm
    import gpio_pd_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic [NPINS-1:0] norm_oe,
    input  logic [NPINS-1:0] norm_out,
    output logic             sleep,
    output logic [NPINS-1:0] hold_oe,
    output logic [NPINS-1:0] hold_out
);

    pwr_state_e state_q, state_d;
    logic       capture;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (pwr_down) begin          // RUN_TO_SLEEP
                    state_d = ST_SLEEP;
                    capture = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!pwr_down) begin         // SLEEP_TO_RUN
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Snapshot of the pad drive taken on entry to power-down
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_oe  <= '0;
            hold_out <= '0;
        end else if (capture) begin
            hold_oe  <= norm_oe;
            hold_out <= norm_out;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_SLEEP: sleep = 1'b1;
            default:  sleep = 1'b0;
        endcase
    end

    // R12: a request seen in RUN moves to SLEEP on that edge
    a_r12_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && pwr_down) |=> (state_q == ST_SLEEP));

    // R12: SLEEP is kept while the request stays high
    a_r12_stay_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && pwr_down) |=> (state_q == ST_SLEEP));

    // R10: a dropped request returns to RUN on the next edge
    a_r10_leave_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && !pwr_down) |=> (state_q == ST_RUN));

    // R8: the snapshot does not move while asleep
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> ($stable(hold_oe) && $stable(hold_out)));

endmodule

// File: rtl/gpio_pd_pad_mux.sv
module gpio_pd_pad_mux
    import gpio_pd_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic [2*NPINS-1:0] pin_mode,
    input  logic [NPINS-1:0]   data_q,
    input  logic [2*NPINS-1:0] pull_q,
    input  logic [2*NPINS-1:0] drv_q,
    input  logic [2*NPINS-1:0] pdm_q,
    input  logic [2*NPINS-1:0] pdpull_q,
    input  logic               sleep,
    input  logic [NPINS-1:0]   hold_oe,
    input  logic [NPINS-1:0]   hold_out,
    output logic [NPINS-1:0]   norm_oe,
    output logic [NPINS-1:0]   norm_out,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [3*NPINS-1:0] pad_drv
);

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic [1:0] pull_sel;

            assign norm_oe[p]  = (pin_mode[2*p +: 2] == PMODE_OUT);
            assign norm_out[p] = norm_oe[p] & data_q[p];

            // Pin drive: normal registers, or the power-down behaviour
            always_comb begin
                if (!sleep) begin
                    pad_oe[p]  = norm_oe[p];
                    pad_out[p] = norm_out[p];
                end else begin
                    unique case (pdm_q[2*p +: 2])
                        PDM_LOW:   begin pad_oe[p] = 1'b1;        pad_out[p] = 1'b0;        end
                        PDM_HIGH:  begin pad_oe[p] = 1'b1;        pad_out[p] = 1'b1;        end
                        PDM_INPUT: begin pad_oe[p] = 1'b0;        pad_out[p] = 1'b0;        end
                        default:   begin pad_oe[p] = hold_oe[p];  pad_out[p] = hold_out[p]; end
                    endcase
                end
            end

            // Pull source follows the power state; reserved code enables neither
            assign pull_sel  = sleep ? pdpull_q[2*p +: 2] : pull_q[2*p +: 2];
            assign pad_pu[p] = (pull_sel == PULL_UP);
            assign pad_pd[p] = (pull_sel == PULL_DOWN);

            assign pad_drv[3*p +: 3] = drive_level(drv_q[2*p +: 2]);

            // R5: both pulls are never on together
            always_comb begin
                a_r5_pull_exclusive: assert (!(pad_pu[p] && pad_pd[p]));
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int NPINS = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [2*NPINS-1:0] pin_mode,
    input  logic [NPINS-1:0]   pin_in,
    input  logic               pwr_down,
    output logic [NPINS-1:0]   pad_oe,
    output logic [NPINS-1:0]   pad_out,
    output logic [NPINS-1:0]   pad_pu,
    output logic [NPINS-1:0]   pad_pd,
    output logic [3*NPINS-1:0] pad_drv
);

    localparam int FW = 2 * NPINS;

    logic [NPINS-1:0] data_q;
    logic [FW-1:0]    pull_q, drv_q, pdm_q, pdpull_q;
    logic             sleep;
    logic [NPINS-1:0] hold_oe, hold_out, norm_oe, norm_out;

    gpio_pd_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_mode  (pin_mode),
        .pin_in    (pin_in),
        .data_q    (data_q),
        .pull_q    (pull_q),
        .drv_q     (drv_q),
        .pdm_q     (pdm_q),
        .pdpull_q  (pdpull_q)
    );

    gpio_pd_pwr_fsm #(.NPINS(NPINS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .norm_oe  (norm_oe),
        .norm_out (norm_out),
        .sleep    (sleep),
        .hold_oe  (hold_oe),
        .hold_out (hold_out)
    );

    gpio_pd_pad_mux #(.NPINS(NPINS)) u_mux (
        .pin_mode (pin_mode),
        .data_q   (data_q),
        .pull_q   (pull_q),
        .drv_q    (drv_q),
        .pdm_q    (pdm_q),
        .pdpull_q (pdpull_q),
        .sleep    (sleep),
        .hold_oe  (hold_oe),
        .hold_out (hold_out),
        .norm_oe  (norm_oe),
        .norm_out (norm_out),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu),
        .pad_pd   (pad_pd),
        .pad_drv  (pad_drv)
    );

    // R10: one edge after the request drops, output pins drive their data bits again
    a_r10_normal_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !pwr_down) |=> (pad_oe == norm_oe && pad_out == norm_out));

endmodule

// File: tb/gpio_pd_port_bench.sv
`timescale 1ns/1ps
module gpio_pd_port_bench;

    localparam int K_RD  = 0;
    localparam int K_OE  = 1;
    localparam int K_OUT = 2;
    localparam int K_PU  = 3;
    localparam int K_PD  = 4;
    localparam int K_DRV = 5;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_mode = 8'h55;
    logic [3:0]  pin_in = '0;
    logic        pwr_down = 1'b0;
    logic [3:0]  pad_oe, pad_out, pad_pu, pad_pd;
    logic [11:0] pad_drv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    gpio_pd_port u_gpio_pd_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_mode  (pin_mode),
        .pin_in    (pin_in),
        .pwr_down  (pwr_down),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_drv   (pad_drv)
    );

    // Monitor: pops expected items and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_OE:    act = {28'd0, pad_oe};
                K_OUT:   act = {28'd0, pad_out};
                K_PU:    act = {28'd0, pad_pu};
                K_PD:    act = {28'd0, pad_pd};
                default: act = {20'd0, pad_drv};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        sb_q.push_back('{kind: K_RD, exp: e, req: req});
        @(negedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic expect_pad(input int k, input logic [31:0] e, input string req);
        sb_q.push_back('{kind: k, exp: e, req: req});
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset contents and reset pad state
        expect_rd(8'h24, 32'h00, "R1 data reset");
        expect_rd(8'h28, 32'h55, "R1 pull reset");
        expect_rd(8'h2C, 32'h00, "R1 drive reset");
        expect_rd(8'h30, 32'h00, "R1 pdmode reset");
        expect_rd(8'h34, 32'h00, "R1 pdpull reset");
        expect_pad(K_PD, 32'hF, "R1 pull-down at reset");
        expect_pad(K_DRV, 32'h249, "R1 drive level 1 at reset");

        // R2: whole-word writes, upper bits read zero
        bus_write(8'h24, 32'hFFFF_FFFF);
        expect_rd(8'h24, 32'h0F, "R2 data upper bits zero");
        bus_write(8'h34, 32'hABCD_12C3);
        expect_rd(8'h34, 32'hC3, "R2 pdpull readback");
        bus_write(8'h34, 32'h0);

        // R3 / R4: per-mode readback and normal pad drive
        pin_mode = 8'h64;   // p0 in, p1 out, p2 alt, p3 out
        pin_in = 4'b0000;
        expect_rd(8'h24, 32'hA, "R3 data read pin_in low");
        pin_in = 4'b0101;
        expect_rd(8'h24, 32'hB, "R3 data read pin_in high");
        expect_pad(K_OE, 32'hA, "R4 oe by mode");
        expect_pad(K_OUT, 32'hA, "R4 out by mode");

        // R5: all pull codes
        bus_write(8'h28, 32'hE4);
        expect_pad(K_PU, 32'h4, "R5 pull-up decode");
        expect_pad(K_PD, 32'h2, "R5 pull-down decode");

        // R6: non-monotonic drive decode
        bus_write(8'h2C, 32'hE4);
        expect_pad(K_DRV, 32'h899, "R6 drive levels");

        // R11: unmapped offsets
        expect_rd(8'h20, 32'h0, "R11 unmapped read 0x20");
        expect_rd(8'h38, 32'h0, "R11 unmapped read 0x38");
        bus_write(8'h38, 32'h0000_00FF);
        bus_write(8'h2D, 32'h0000_00FF);
        expect_rd(8'h2C, 32'hE4, "R11 drive untouched");
        expect_rd(8'h28, 32'hE4, "R11 pull untouched");

        // Power-down pass
        pin_mode = 8'h55;
        bus_write(8'h28, 32'h55);
        bus_write(8'h24, 32'h8);
        bus_write(8'h30, 32'hE4);   // p0 low, p1 high, p2 input, p3 keep
        bus_write(8'h34, 32'h36);   // p0 up, p1 down, p2 reserved, p3 none
        expect_pad(K_PU, 32'h0, "R9 normal pull-up while running");
        expect_pad(K_PD, 32'hF, "R9 normal pull-down while running");
        expect_pad(K_OUT, 32'h8, "R4 out before sleep");

        pwr_down = 1'b1;
        tick();
        expect_pad(K_OE, 32'hB, "R7 R12 sleep oe");
        expect_pad(K_OUT, 32'hA, "R7 R8 sleep out");
        expect_pad(K_PU, 32'h1, "R9 sleep pull-up");
        expect_pad(K_PD, 32'h2, "R9 sleep pull-down");
        bus_write(8'h24, 32'h0);
        tick();
        expect_pad(K_OUT, 32'hA, "R8 held pin ignores data write");
        expect_pad(K_OE, 32'hB, "R12 still asleep");

        pwr_down = 1'b0;
        tick();
        expect_pad(K_OE, 32'hF, "R10 oe back to normal");
        expect_pad(K_OUT, 32'h0, "R10 out back to normal");
        expect_pad(K_PD, 32'hF, "R10 pull back to normal");
        expect_rd(8'h30, 32'hE4, "R10 pdmode unchanged");
        expect_rd(8'h34, 32'h36, "R10 pdpull unchanged");
        expect_rd(8'h24, 32'h0, "R10 data unchanged");

        repeat (2) tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule